// File: doc/BRIEF.md
# Preempted channel sequence scanner

This block runs a short, high-priority conversion sequence for an analog-to-digital converter front end. Software programs a 32-bit sequence configuration word with a step count and four 5-bit channel numbers. A start trigger then makes the block walk the active steps. For each step it raises a one-cycle request carrying the channel number and waits for the converter's done strobe. It stores the returned 16-bit result in a per-step data register, and at the end of the run it reports completion.

When the sequence is shorter than four steps, the active steps are the last ones among the four channel fields. A two-step sequence therefore converts the channels in fields 3 and 4. The step count and the channel list are captured when a run starts, so software may prepare the next sequence while a run is still in progress. A channel number outside the valid range is skipped and recorded as a configuration error. The analog converter itself sits outside the block and answers the request/done handshake.

Top module: `pseq_scanner`

## Requirements
- R1: After reset, every register reads zero, `busy` is low and no request is issued. The registers are: configuration at address 0, status at address 1, and data registers 1..4 at addresses 2..5.
- R2: In the configuration word, field k (k = 1..4) is at bits 5k-1:5k-5, and the length code is at bits 21:20. Bits 31:22 read zero and ignore writes.
- R3: With length code c, the run converts c+1 steps, taken from fields 4-c through 4 in ascending order. For example, code 2 with fields 1..4 = 3,4,5,6 converts channels 4, 5 and 6.
- R4: Each valid step produces exactly one single-cycle `conv_req` with `conv_chan` set to the field value. The next step starts only after `conv_done`. `conv_done` outside a wait has no effect, and `conv_chan` is zero when no request is active.
- R5: The k-th conversion actually completed in a run is written to data register k. Data registers hold the result in bits 15:0, and bits 31:16 read zero. Data registers not reached keep their contents. Software writes to bits 15:0 are accepted, and a capture in the same cycle wins.
- R6: A field value above 17 is skipped without a request. Skipping sets the sticky error bit, status bit 1, which is cleared by writing 1 to it.
- R7: When the last step finishes, `seq_end_pulse` is high for exactly one cycle. The same edge sets the sticky done bit, status bit 0, which is cleared by writing 1 to it. Status bit 2 mirrors `busy`.
- R8: A start trigger while a run is in progress is ignored.
- R9: The length and channel fields are snapshotted at the start. Configuration writes during a run affect only the next run.
- R10: `busy` rises the cycle after an accepted start and falls in the cycle of `seq_end_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| start_trig | input | 1 | Sequence start trigger |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 5 | Channel to convert |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 16 | Converter result, valid with `conv_done` |
| seq_end_pulse | output | 1 | End-of-sequence pulse |
| busy | output | 1 | Run in progress |

## Verification
The sequencer is exercised with the full four-step length, the three-step example, and a one-step run at the highest valid channel. Together these show whether the scan starts from the top end of the fields. One run mixes valid fields with out-of-range ones, which separates skipping from converting and shows that results pack into consecutive data registers. An all-invalid one-step run shows that a run can end with no request at all. Further runs use different converter latencies, a second start and a configuration rewrite during a run, and a stray done strobe while idle. These separate the snapshot behaviour from the live register and show that the handshake ignores done strobes outside a wait.

// File: rtl/pseq_pkg.sv
`timescale 1ns/1ps
package pseq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } pseq_state_e;

   localparam int unsigned ADDR_CFG       = 0;
   localparam int unsigned ADDR_STAT      = 1;
   localparam int unsigned ADDR_DATA_BASE = 2;
endpackage

// File: rtl/pseq_field_pick.sv
`timescale 1ns/1ps
module pseq_field_pick #(
   parameter int STEPS    = 4,
   parameter int CHAN_W   = 5,
   parameter int MAX_CHAN = 17,
   parameter int IDX_W    = 2
) (
   input  logic [STEPS*CHAN_W-1:0] fields,
   input  logic [IDX_W-1:0]        idx,
   output logic [CHAN_W-1:0]       chan,
   output logic                    chan_ok
);
   logic [STEPS-1:0][CHAN_W-1:0] field_arr;

   for (genvar i = 0; i < STEPS; i++) begin : g_unpack
      assign field_arr[i] = fields[i*CHAN_W +: CHAN_W];
   end

   assign chan = field_arr[idx];

   // Range check only exists when some field codes are out of range
   if (MAX_CHAN >= (2**CHAN_W) - 1) begin : g_all_valid
      assign chan_ok = 1'b1;
   end else begin : g_range_chk
      assign chan_ok = (chan <= CHAN_W'(MAX_CHAN));
   end
endmodule

// File: rtl/pseq_regs.sv
`timescale 1ns/1ps
module pseq_regs
   import pseq_pkg::*;
#(
   parameter int STEPS  = 4,
   parameter int DATA_W = 16,
   parameter int REG_W  = 32,
   parameter int ADDR_W = 3,
   parameter int CFG_W  = 22,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              busy,
   input  logic              set_done,
   input  logic              set_err,
   input  logic              cap_en,
   input  logic [IDX_W-1:0]  cap_idx,
   input  logic [DATA_W-1:0] cap_data,
   output logic [CFG_W-1:0]  cfg_q
);
   logic                         done_r, err_r;
   logic                         stat_wr;
   logic [STEPS-1:0][DATA_W-1:0] data_vec;
   logic                         unused_wdata_hi;

   assign unused_wdata_hi = ^reg_wdata[REG_W-1:CFG_W];
   assign stat_wr = reg_we && (reg_addr == ADDR_W'(ADDR_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (reg_we && (reg_addr == ADDR_W'(ADDR_CFG))) begin
         cfg_q <= reg_wdata[CFG_W-1:0];
      end
   end

   // Sticky flags: a set in the same cycle beats a write-one clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_r <= 1'b0;
         err_r  <= 1'b0;
      end else begin
         done_r <= (done_r & ~(stat_wr & reg_wdata[0])) | set_done;
         err_r  <= (err_r  & ~(stat_wr & reg_wdata[1])) | set_err;
      end
   end

   for (genvar i = 0; i < STEPS; i++) begin : g_data
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (cap_en && (cap_idx == IDX_W'(i))) begin
            q <= cap_data;
         end else if (reg_we && (reg_addr == ADDR_W'(ADDR_DATA_BASE + i))) begin
            q <= reg_wdata[DATA_W-1:0];
         end
      end
      assign data_vec[i] = q;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADDR_CFG)) begin
         reg_rdata[CFG_W-1:0] = cfg_q;
      end
      if (reg_addr == ADDR_W'(ADDR_STAT)) begin
         reg_rdata[2:0] = {busy, err_r, done_r};
      end
      for (int i = 0; i < STEPS; i++) begin
         if (reg_addr == ADDR_W'(ADDR_DATA_BASE + i)) begin
            reg_rdata[DATA_W-1:0] = data_vec[i];
         end
      end
   end
endmodule

// File: rtl/pseq_fsm.sv
`timescale 1ns/1ps
module pseq_fsm
   import pseq_pkg::*;
#(
   parameter int STEPS    = 4,
   parameter int CHAN_W   = 5,
   parameter int MAX_CHAN = 17,
   parameter int DATA_W   = 16,
   parameter int LEN_W    = 2,
   parameter int IDX_W    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_trig,
   input  logic [STEPS*CHAN_W+LEN_W-1:0] cfg_q,
   input  logic                      conv_done,
   input  logic [DATA_W-1:0]         conv_data,
   output logic                      conv_req,
   output logic [CHAN_W-1:0]         conv_chan,
   output logic                      busy,
   output logic                      seq_end_pulse,
   output logic                      set_done,
   output logic                      set_err,
   output logic                      cap_en,
   output logic [IDX_W-1:0]          cap_idx,
   output logic [DATA_W-1:0]         cap_data
);
   localparam int FLD_W = STEPS * CHAN_W;

   pseq_state_e       state_q, state_d;
   logic [FLD_W-1:0]  snap_q, snap_d;
   logic [IDX_W-1:0]  step_q, step_d;
   logic [IDX_W-1:0]  wr_q, wr_d;
   logic              end_q;
   logic              finish;
   logic              last_step;
   logic [CHAN_W-1:0] cur_chan;
   logic              cur_ok;

   pseq_field_pick #(
      .STEPS(STEPS), .CHAN_W(CHAN_W), .MAX_CHAN(MAX_CHAN), .IDX_W(IDX_W)
   ) u_pick (
      .fields (snap_q),
      .idx    (step_q),
      .chan   (cur_chan),
      .chan_ok(cur_ok)
   );

   assign last_step = (step_q == IDX_W'(STEPS - 1));

   always_comb begin
      state_d = state_q;
      snap_d  = snap_q;
      step_d  = step_q;
      wr_d    = wr_q;
      finish  = 1'b0;
      set_err = 1'b0;
      cap_en  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_trig) begin
               snap_d  = cfg_q[FLD_W-1:0];
               // Short sequences occupy the top end of the field list
               step_d  = IDX_W'(STEPS - 1) - cfg_q[FLD_W +: LEN_W];
               wr_d    = '0;
               state_d = ST_REQ;
            end
         end
         ST_REQ: begin
            if (cur_ok) begin
               state_d = ST_WAIT;
            end else begin
               set_err = 1'b1;
               if (last_step) begin
                  finish  = 1'b1;
                  state_d = ST_IDLE;
               end else begin
                  step_d = step_q + IDX_W'(1);
               end
            end
         end
         ST_WAIT: begin
            if (conv_done) begin
               cap_en = 1'b1;
               wr_d   = wr_q + IDX_W'(1);
               if (last_step) begin
                  finish  = 1'b1;
                  state_d = ST_IDLE;
               end else begin
                  step_d  = step_q + IDX_W'(1);
                  state_d = ST_REQ;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         snap_q  <= '0;
         step_q  <= '0;
         wr_q    <= '0;
         end_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         snap_q  <= snap_d;
         step_q  <= step_d;
         wr_q    <= wr_d;
         end_q   <= finish;
      end
   end

   assign conv_req      = (state_q == ST_REQ) && cur_ok;
   assign conv_chan     = conv_req ? cur_chan : '0;
   assign busy          = (state_q != ST_IDLE);
   assign seq_end_pulse = end_q;
   assign set_done      = finish;
   assign cap_idx       = wr_q;
   assign cap_data      = conv_data;
endmodule

// File: rtl/pseq_scanner.sv
`timescale 1ns/1ps
module pseq_scanner
   import pseq_pkg::*;
#(
   parameter int STEPS    = 4,
   parameter int CHAN_W   = 5,
   parameter int MAX_CHAN = 17,
   parameter int DATA_W   = 16,
   parameter int REG_W    = 32,
   parameter int ADDR_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              start_trig,
   output logic              conv_req,
   output logic [CHAN_W-1:0] conv_chan,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic              seq_end_pulse,
   output logic              busy
);
   localparam int LEN_W = $clog2(STEPS);
   localparam int CFG_W = STEPS * CHAN_W + LEN_W;

   if (STEPS < 2 || (1 << LEN_W) != STEPS) begin : g_bad_steps
      $error("STEPS must be a power of two of at least 2");
   end
   if (CFG_W > REG_W) begin : g_bad_cfg
      $error("configuration word does not fit the register width");
   end
   if (DATA_W > REG_W) begin : g_bad_data
      $error("result width exceeds the register width");
   end
   if (MAX_CHAN >= (2**CHAN_W)) begin : g_bad_chan
      $error("MAX_CHAN not representable in CHAN_W bits");
   end
   if (ADDR_DATA_BASE + STEPS > (2**ADDR_W)) begin : g_bad_addr
      $error("address space too small for the data registers");
   end

   logic [CFG_W-1:0]  cfg_q;
   logic              set_done, set_err, cap_en;
   logic [LEN_W-1:0]  cap_idx;
   logic [DATA_W-1:0] cap_data;

   pseq_regs #(
      .STEPS(STEPS), .DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W),
      .CFG_W(CFG_W), .IDX_W(LEN_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_we   (reg_we),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .busy     (busy),
      .set_done (set_done),
      .set_err  (set_err),
      .cap_en   (cap_en),
      .cap_idx  (cap_idx),
      .cap_data (cap_data),
      .cfg_q    (cfg_q)
   );

   pseq_fsm #(
      .STEPS(STEPS), .CHAN_W(CHAN_W), .MAX_CHAN(MAX_CHAN), .DATA_W(DATA_W),
      .LEN_W(LEN_W), .IDX_W(LEN_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_trig   (start_trig),
      .cfg_q        (cfg_q),
      .conv_done    (conv_done),
      .conv_data    (conv_data),
      .conv_req     (conv_req),
      .conv_chan    (conv_chan),
      .busy         (busy),
      .seq_end_pulse(seq_end_pulse),
      .set_done     (set_done),
      .set_err      (set_err),
      .cap_en       (cap_en),
      .cap_idx      (cap_idx),
      .cap_data     (cap_data)
   );
endmodule

// File: rtl/pseq_scanner_chk.sv
`timescale 1ns/1ps
module pseq_scanner_chk
   import pseq_pkg::*;
#(
   parameter int STEPS    = 4,
   parameter int CHAN_W   = 5,
   parameter int MAX_CHAN = 17,
   parameter int DATA_W   = 16,
   parameter int REG_W    = 32,
   parameter int ADDR_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [REG_W-1:0]  reg_rdata,
   input logic              start_trig,
   input logic              conv_req,
   input logic [CHAN_W-1:0] conv_chan,
   input logic              seq_end_pulse,
   input logic              busy
);
   localparam int CFG_W = STEPS * CHAN_W + $clog2(STEPS);

   logic unused_rdata_lo;
   assign unused_rdata_lo = ^reg_rdata[DATA_W-1:0];

   // R4: a request lasts a single cycle
   p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req) else $error("request longer than one cycle");

   // R6: no request ever names an out-of-range channel
   p_req_chan_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> (conv_chan <= CHAN_W'(MAX_CHAN))) else $error("bad channel requested");

   p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> busy) else $error("request while idle");

   p_end_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_end_pulse |=> !seq_end_pulse) else $error("end pulse longer than one cycle");

   p_end_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> seq_end_pulse) else $error("run ended without end pulse");

   p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      seq_end_pulse |-> !busy) else $error("busy during end pulse");

   p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start_trig) |=> busy) else $error("start not accepted");

   p_cfg_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(ADDR_CFG)) |-> (reg_rdata[REG_W-1:CFG_W] == '0))
      else $error("reserved configuration bits nonzero");

   p_data_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_addr >= ADDR_W'(ADDR_DATA_BASE)) && (reg_addr < ADDR_W'(ADDR_DATA_BASE + STEPS)))
      |-> (reg_rdata[REG_W-1:DATA_W] == '0)) else $error("data upper bits nonzero");
endmodule

bind pseq_scanner pseq_scanner_chk #(
   .STEPS(STEPS), .CHAN_W(CHAN_W), .MAX_CHAN(MAX_CHAN), .DATA_W(DATA_W),
   .REG_W(REG_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_addr     (reg_addr),
   .reg_rdata    (reg_rdata),
   .start_trig   (start_trig),
   .conv_req     (conv_req),
   .conv_chan    (conv_chan),
   .seq_end_pulse(seq_end_pulse),
   .busy         (busy)
);

// File: tb/pseq_scanner_bench.sv
`timescale 1ns/1ps
module pseq_scanner_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        start_trig = 1'b0;
   logic        conv_req;
   logic [4:0]  conv_chan;
   logic        conv_done = 1'b0;
   logic [15:0] conv_data = '0;
   logic        seq_end_pulse;
   logic        busy;

   always #4 clk = ~clk;  // 125 MHz

   pseq_scanner u_pseq_scanner (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_trig(start_trig),
      .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
      .conv_data(conv_data), .seq_end_pulse(seq_end_pulse), .busy(busy)
   );

   int checks = 0;
   int errors = 0;
   bit fin = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int          m_phase = 0;  // 0 idle, 1 request, 2 wait
   int          m_q[$];
   logic [31:0] m_cfg = '0;
   logic [15:0] m_data[4] = '{default: '0};
   bit          m_done = 0, m_err = 0, m_end = 0;
   int          m_k = 0;

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_cfg;
         3'd1: return {29'b0, m_phase != 0, m_err, m_done};
         3'd2, 3'd3, 3'd4, 3'd5: return {16'b0, m_data[int'(a) - 2]};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin : ref_model
      int k;
      logic [15:0] v;
      bit cap, sdone, serr;
      if (!rst_n) begin
         m_phase = 0; m_q.delete(); m_cfg = '0; m_k = 0;
         foreach (m_data[i]) m_data[i] = '0;
         m_done = 0; m_err = 0; m_end = 0;
      end else begin
         cap = 0; sdone = 0; serr = 0; m_end = 0; k = 0; v = '0;
         case (m_phase)
            0: if (start_trig) begin
               m_q.delete();
               for (int f = 3 - int'(m_cfg[21:20]); f < 4; f++)
                  m_q.push_back(int'((m_cfg >> (5 * f)) & 32'h1F));
               m_k = 0;
               m_phase = 1;
            end
            1: if (m_q[0] > 17) begin
               serr = 1;
               void'(m_q.pop_front());
               if (m_q.size() == 0) begin sdone = 1; m_phase = 0; end
            end else m_phase = 2;
            default: if (conv_done) begin
               cap = 1; k = m_k; v = conv_data; m_k++;
               void'(m_q.pop_front());
               if (m_q.size() == 0) begin sdone = 1; m_phase = 0; end
               else m_phase = 1;
            end
         endcase
         if (reg_we) begin
            case (reg_addr)
               3'd0: m_cfg = reg_wdata & 32'h003F_FFFF;
               3'd1: begin
                  if (reg_wdata[0]) m_done = 0;
                  if (reg_wdata[1]) m_err = 0;
               end
               3'd2, 3'd3, 3'd4, 3'd5: m_data[int'(reg_addr) - 2] = reg_wdata[15:0];
               default: ;
            endcase
         end
         if (sdone) begin m_done = 1; m_end = 1; end
         if (serr) m_err = 1;
         if (cap) m_data[k] = v;
      end
   end

   // ---------------- cycle compare ----------------
   always @(negedge clk) begin : cmp
      bit er;
      logic [4:0] ec;
      string rtag;
      #2;
      if (rst_n && !fin) begin
         er = (m_phase == 1) && (m_q[0] <= 17);
         ec = er ? 5'(m_q[0]) : 5'd0;
         rtag = (reg_addr == 3'd0) ? "R2" : (reg_addr == 3'd1) ? "R7" : "R5";
         chk(conv_req === er, "R4", "conv_req", 32'(conv_req), 32'(er));
         chk(conv_chan === ec, "R4", "conv_chan", 32'(conv_chan), 32'(ec));
         chk(busy === (m_phase != 0), "R10", "busy", 32'(busy), 32'(m_phase != 0));
         chk(seq_end_pulse === m_end, "R7", "seq_end_pulse", 32'(seq_end_pulse), 32'(m_end));
         chk(reg_rdata === m_read(reg_addr), rtag, "reg_rdata", reg_rdata, m_read(reg_addr));
      end
   end

   // ---------------- converter model and log ----------------
   int       conv_lat = 1;
   int       cnt = 0;
   int       rsp_n = 0;
   logic [4:0] rsp_chan = '0;
   int       stray_cnt = 0, stray_seen = 0;
   int       chan_log[$];
   int       n_end = 0;

   always @(negedge clk) begin : conv_model
      conv_done = 1'b0;
      if (stray_cnt != stray_seen) begin
         stray_seen = stray_cnt;
         conv_done = 1'b1;
         conv_data = 16'hDEAD;
      end
      if (cnt > 0) begin
         cnt--;
         if (cnt == 0) begin
            conv_done = 1'b1;
            conv_data = {rsp_n[7:0], 3'b000, rsp_chan};
            rsp_n++;
         end
      end
      if (rst_n && conv_req) begin
         cnt = conv_lat;
         rsp_chan = conv_chan;
         chan_log.push_back(int'(conv_chan));
      end
      if (rst_n && seq_end_pulse) n_end++;
   end

   // ---------------- helpers ----------------
   function automatic logic [31:0] mk_cfg(input int c, input int f1, input int f2,
                                         input int f3, input int f4);
      return {10'b0, 2'(c), 5'(f4), 5'(f3), 5'(f2), 5'(f1)};
   endfunction

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic pulse_start;
      @(negedge clk); start_trig = 1'b1;
      @(negedge clk); start_trig = 1'b0;
   endtask

   task automatic run_wait;
      int e0;
      e0 = n_end;
      pulse_start();
      while (n_end == e0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic chk_list(input string tag, input int base, input int exp[$]);
      chk(chan_log.size() - base == exp.size(), tag, "request count",
          32'(chan_log.size() - base), 32'(exp.size()));
      foreach (exp[i])
         if (base + i < chan_log.size())
            chk(chan_log[base + i] == exp[i], tag, "requested channel",
                32'(chan_log[base + i]), 32'(exp[i]));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         errors++;
         $display("FAIL R4 watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- directed scenarios ----------------
   initial begin
      logic [31:0] d, d4, d1;
      int base, e0;
      int e[$];
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), d);
         chk(d == 32'h0, "R1", "reset register value", d, 32'h0);
      end
      chk(busy == 1'b0 && conv_req == 1'b0, "R1", "idle after reset", 32'({busy, conv_req}), 32'h0);

      // R2: layout and reserved bits
      wr(3'd0, 32'hFFC0_0000 | mk_cfg(3, 1, 2, 3, 4));
      rd(3'd0, d);
      chk(d == mk_cfg(3, 1, 2, 3, 4), "R2", "config readback", d, mk_cfg(3, 1, 2, 3, 4));

      // R3: four-step run
      base = chan_log.size(); e0 = n_end;
      run_wait();
      e = {1, 2, 3, 4};
      chk_list("R3", base, e);
      chk(n_end - e0 == 1, "R7", "end pulses", 32'(n_end - e0), 32'd1);
      rd(3'd1, d);
      chk(d[0] == 1'b1, "R7", "done bit", 32'(d[0]), 32'd1);
      rd(3'd5, d4);

      // R3: three-step example uses top fields; R5 packing
      wr(3'd0, mk_cfg(2, 3, 4, 5, 6));
      base = chan_log.size();
      run_wait();
      e = {4, 5, 6};
      chk_list("R3", base, e);
      rd(3'd5, d);
      chk(d == d4, "R5", "data reg 4 untouched", d, d4);
      rd(3'd2, d);
      chk(d[4:0] == 5'd4 && d[31:16] == 16'h0, "R5", "data reg 1 holds first result", d, 32'(d[15:5]) << 5 | 32'd4);

      // R7: write-one clear of done
      wr(3'd1, 32'h1);
      rd(3'd1, d);
      chk(d[0] == 1'b0, "R7", "done cleared", 32'(d[0]), 32'd0);

      // R3: one step at the top valid channel
      wr(3'd0, mk_cfg(0, 9, 9, 9, 17));
      base = chan_log.size();
      run_wait();
      e = {17};
      chk_list("R3", base, e);

      // R6: invalid fields skipped, results pack, longer latency
      conv_lat = 3;
      wr(3'd0, mk_cfg(3, 2, 18, 31, 7));
      base = chan_log.size();
      run_wait();
      e = {2, 7};
      chk_list("R6", base, e);
      rd(3'd1, d);
      chk(d[1] == 1'b1, "R6", "error bit set", 32'(d[1]), 32'd1);
      rd(3'd3, d);
      chk(d[4:0] == 5'd7, "R5", "data reg 2 holds second executed", 32'(d[4:0]), 32'd7);
      wr(3'd1, 32'h2);
      rd(3'd1, d);
      chk(d[1] == 1'b0, "R6", "error bit cleared", 32'(d[1]), 32'd0);

      // R6: all-invalid single step
      wr(3'd0, mk_cfg(0, 0, 0, 0, 20));
      base = chan_log.size(); e0 = n_end;
      run_wait();
      e = {};
      chk_list("R6", base, e);
      chk(n_end - e0 == 1, "R7", "end pulse with no request", 32'(n_end - e0), 32'd1);
      rd(3'd1, d);
      chk(d[1] == 1'b1, "R6", "error bit set again", 32'(d[1]), 32'd1);

      // R8 and R9: restart and rewrite during a run
      conv_lat = 4;
      wr(3'd0, mk_cfg(3, 1, 3, 5, 7));
      base = chan_log.size(); e0 = n_end;
      pulse_start();
      repeat (3) @(negedge clk);
      pulse_start();
      wr(3'd0, mk_cfg(3, 8, 8, 8, 8));
      while (n_end == e0) @(negedge clk);
      repeat (12) @(negedge clk);
      e = {1, 3, 5, 7};
      chk_list("R9", base, e);
      chk(n_end - e0 == 1, "R8", "single run despite second start", 32'(n_end - e0), 32'd1);
      base = chan_log.size();
      run_wait();
      e = {8, 8, 8, 8};
      chk_list("R9", base, e);

      // R4: stray done while idle has no effect
      rd(3'd2, d1);
      @(posedge clk); stray_cnt++;
      repeat (3) @(negedge clk);
      rd(3'd2, d);
      chk(d == d1, "R4", "stray done ignored", d, d1);
      chk(busy == 1'b0, "R4", "still idle after stray done", 32'(busy), 32'd0);

      // R5: software write to a data register
      wr(3'd4, 32'hFFFF_1234);
      rd(3'd4, d);
      chk(d == 32'h0000_1234, "R5", "data reg write", d, 32'h0000_1234);

      repeat (2) @(negedge clk);
      fin = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule